// File: doc/BRIEF.md
# Rail Tracking Reference Selector

This block produces the reference code for one regulated rail. It picks a master signal, which is either the reference of another internal rail or an external tracking input, and multiplies that master by a configured fixed-point ratio. The result is compared with the rail's own target. The block then decides whether the rail follows the scaled master or holds the target, and it raises a gain-select flag that tells the compensator which coefficient set to use. A rail can also be left independent, with no master, and then it simply heads for its target.

The reference moves only on an update tick and is rate-limited, so neither a power-up nor a change of master produces a step. Two event flags from the loop override the normal motion. A saturation flag freezes the reference, and a current-limit flag folds the reference back. In both cases the rail departs from the tracked value for as long as the flag is active, and this applies in either mode.

Top module: `rail_track_ref`

## Requirements
- R1: After reset `ref_code` is 0 and `gain_reg` is 0, which means the follow mode with start-stop gains is selected.
- R2: `src_sel` values 0 to N_RAILS-1 select slice k of `rails_ref` (bits k*REF_W upward). The value N_RAILS selects `ext_track`. Any larger value makes the rail independent: at the next tick it uses the target as its goal and sets `gain_reg` to 1.
- R3: The followed value is floor(master * ratio / 2^RATIO_FRAC), clamped to the largest code. With the default settings a ratio of 64 gives half the master and 128 gives the master itself.
- R4: At a tick in follow mode, a scaled master strictly above `target` switches the rail to regulation. The goal becomes `target` and `gain_reg` becomes 1.
- R5: In regulation, a tick returns the rail to follow mode (`gain_reg` 0) only when scaled + HYST_CODE < target, where the default HYST_CODE of 20 codes represents 20 mV at a 1 mV LSB. Inside the band the rail stays in regulation.
- R6: At a tick with no event flag set, `ref_code` moves toward the goal by min(|goal - ref_code|, SLEW_MAX). The default SLEW_MAX is 16. This gives a step-free start and step-free master changes.
- R7: Between ticks, `ref_code` and `gain_reg` do not change, whatever the other inputs do.
- R8: At a tick with `sat_flag` set and `ilim_flag` clear, `ref_code` keeps its value. The mode decision still takes place.
- R9: At a tick with `ilim_flag` set, `ref_code` drops by FOLD_STEP (default 32), floored at 0, whatever the state of `sat_flag`.
- R10: With `target` at the largest code, the rail never leaves follow mode, so `gain_reg` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Reference update strobe |
| src_sel | input | SEL_W | Master selection |
| rails_ref | input | N_RAILS*REF_W | Packed references of the internal rails |
| ext_track | input | REF_W | External tracking input code |
| ratio | input | RATIO_W | Scale ratio with RATIO_FRAC fractional bits |
| target | input | REF_W | The rail's own target code |
| sat_flag | input | 1 | Error converter saturated |
| ilim_flag | input | 1 | Current limit active |
| ref_code | output | REF_W | Reference code |
| gain_reg | output | 1 | 1 selects regulation gains, 0 selects start-stop gains |

## Verification
The hardest state to reach is the hysteresis band. The rail must first be driven into regulation by a scaled master above the target. The master must then be lowered into the window between target-20 and target, where the rail has to stay in regulation, and after that lowered below the window. Directed steps set up exactly this sequence with the external source at unit ratio, and they hit both edges of the band. A random phase then mixes source changes, ratios and event flags, and a bench model follows it tick by tick.

// File: rtl/rtp_pkg.sv
package rtp_pkg;
   typedef enum logic {
      MODE_FOLLOW   = 1'b0,
      MODE_REGULATE = 1'b1
   } rtp_mode_e;
endpackage

// File: rtl/rtp_master_scale.sv
module rtp_master_scale #(
   parameter int N_RAILS    = 4,
   parameter int REF_W      = 12,
   parameter int RATIO_W    = 8,
   parameter int RATIO_FRAC = 7,
   parameter int SEL_W      = 3
) (
   input  logic [SEL_W-1:0]         src_sel,
   input  logic [N_RAILS*REF_W-1:0] rails_ref,
   input  logic [REF_W-1:0]         ext_track,
   input  logic [RATIO_W-1:0]       ratio,
   output logic                     indep,
   output logic [REF_W-1:0]         scaled
);
   localparam int PROD_W = REF_W + RATIO_W;

   logic [REF_W-1:0]  rail_arr [N_RAILS];
   logic [REF_W-1:0]  master;
   logic [PROD_W-1:0] prod;
   logic [PROD_W-1:0] shifted;

   for (genvar k = 0; k < N_RAILS; k++) begin : g_unpack
      assign rail_arr[k] = rails_ref[k*REF_W +: REF_W];
   end

   always_comb begin
      master = ext_track;
      indep  = 1'b0;
      if (int'(src_sel) < N_RAILS)
         master = rail_arr[src_sel];
      else if (int'(src_sel) > N_RAILS)
         indep = 1'b1;
   end

   assign prod    = PROD_W'(master) * PROD_W'(ratio);
   assign shifted = prod >> RATIO_FRAC;

   if (RATIO_W > RATIO_FRAC) begin : g_clamp
      assign scaled = (|shifted[PROD_W-1:REF_W]) ? {REF_W{1'b1}} : shifted[REF_W-1:0];
   end else begin : g_noclamp
      assign scaled = shifted[REF_W-1:0];
   end
endmodule

// File: rtl/rtp_mode_ctl.sv
module rtp_mode_ctl
   import rtp_pkg::*;
#(
   parameter int REF_W     = 12,
   parameter int HYST_CODE = 20
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             indep,
   input  logic [REF_W-1:0] scaled,
   input  logic [REF_W-1:0] target,
   output rtp_mode_e        mode_d,
   output rtp_mode_e        mode_q
);
   localparam int CW = REF_W + 2;

   logic above;
   logic below_band;

   assign above      = scaled > target;
   assign below_band = (CW'(scaled) + CW'(HYST_CODE)) < CW'(target);

   always_comb begin
      mode_d = mode_q;
      if (indep)
         mode_d = MODE_REGULATE;
      else if (mode_q == MODE_FOLLOW && above)
         mode_d = MODE_REGULATE;
      else if (mode_q == MODE_REGULATE && below_band)
         mode_d = MODE_FOLLOW;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         mode_q <= MODE_FOLLOW;
      else if (tick)
         mode_q <= mode_d;
   end

   assert_enter_reg_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && mode_q == MODE_FOLLOW && scaled > target) |=> mode_q == MODE_REGULATE);

   assert_band_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && mode_q == MODE_REGULATE &&
       (CW'(scaled) + CW'(HYST_CODE) >= CW'(target))) |=> mode_q == MODE_REGULATE);

   assert_mode_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> $stable(mode_q));
endmodule

// File: rtl/rtp_slew.sv
module rtp_slew #(
   parameter int REF_W     = 12,
   parameter int SLEW_MAX  = 16,
   parameter int FOLD_STEP = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             sat_flag,
   input  logic             ilim_flag,
   input  logic [REF_W-1:0] goal,
   output logic [REF_W-1:0] ref_q
);
   localparam int              XW     = REF_W + 1;
   localparam logic [REF_W-1:0] SLEW_C = REF_W'(SLEW_MAX);
   localparam logic [REF_W-1:0] FOLD_C = REF_W'(FOLD_STEP);

   logic [REF_W-1:0] ref_d;

   always_comb begin
      ref_d = ref_q;
      if (ilim_flag)
         ref_d = (ref_q > FOLD_C) ? ref_q - FOLD_C : '0;
      else if (sat_flag)
         ref_d = ref_q;
      else if (goal > ref_q)
         ref_d = (goal - ref_q > SLEW_C) ? ref_q + SLEW_C : goal;
      else if (goal < ref_q)
         ref_d = (ref_q - goal > SLEW_C) ? ref_q - SLEW_C : goal;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         ref_q <= '0;
      else if (tick)
         ref_q <= ref_d;
   end

   assert_slew_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !ilim_flag) |=>
         (XW'(ref_q) <= XW'($past(ref_q)) + XW'(SLEW_MAX)) &&
         (XW'(ref_q) + XW'(SLEW_MAX) >= XW'($past(ref_q))));

   assert_ref_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> $stable(ref_q));

   assert_sat_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && sat_flag && !ilim_flag) |=> $stable(ref_q));

   assert_fold_down_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && ilim_flag && ref_q != '0) |=> ref_q < $past(ref_q));
endmodule

// File: rtl/rail_track_ref.sv
module rail_track_ref
   import rtp_pkg::*;
#(
   parameter int N_RAILS    = 4,
   parameter int REF_W      = 12,
   parameter int RATIO_W    = 8,
   parameter int RATIO_FRAC = 7,
   parameter int HYST_CODE  = 20,
   parameter int SLEW_MAX   = 16,
   parameter int FOLD_STEP  = 32,
   parameter int SEL_W      = $clog2(N_RAILS + 2)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     tick,
   input  logic [SEL_W-1:0]         src_sel,
   input  logic [N_RAILS*REF_W-1:0] rails_ref,
   input  logic [REF_W-1:0]         ext_track,
   input  logic [RATIO_W-1:0]       ratio,
   input  logic [REF_W-1:0]         target,
   input  logic                     sat_flag,
   input  logic                     ilim_flag,
   output logic [REF_W-1:0]         ref_code,
   output logic                     gain_reg
);
   if (N_RAILS < 1) begin : g_chk_rails
      $error("N_RAILS must be at least 1");
   end
   if (RATIO_FRAC > RATIO_W) begin : g_chk_frac
      $error("RATIO_FRAC exceeds RATIO_W");
   end
   if (SLEW_MAX < 1 || SLEW_MAX >= (1 << REF_W)) begin : g_chk_slew
      $error("SLEW_MAX out of range");
   end
   if (HYST_CODE < 0 || HYST_CODE >= (1 << REF_W)) begin : g_chk_hyst
      $error("HYST_CODE out of range");
   end
   if ((1 << SEL_W) < N_RAILS + 2) begin : g_chk_sel
      $error("SEL_W too narrow for sources");
   end

   logic             indep;
   logic [REF_W-1:0] scaled;
   logic [REF_W-1:0] goal;
   rtp_mode_e        mode_d;
   rtp_mode_e        mode_q;

   rtp_master_scale #(
      .N_RAILS(N_RAILS), .REF_W(REF_W), .RATIO_W(RATIO_W),
      .RATIO_FRAC(RATIO_FRAC), .SEL_W(SEL_W)
   ) u_scale (
      .src_sel(src_sel), .rails_ref(rails_ref), .ext_track(ext_track),
      .ratio(ratio), .indep(indep), .scaled(scaled)
   );

   rtp_mode_ctl #(
      .REF_W(REF_W), .HYST_CODE(HYST_CODE)
   ) u_mode (
      .clk(clk), .rst_n(rst_n), .tick(tick), .indep(indep),
      .scaled(scaled), .target(target), .mode_d(mode_d), .mode_q(mode_q)
   );

   assign goal = (mode_d == MODE_REGULATE) ? target : scaled;

   rtp_slew #(
      .REF_W(REF_W), .SLEW_MAX(SLEW_MAX), .FOLD_STEP(FOLD_STEP)
   ) u_slew (
      .clk(clk), .rst_n(rst_n), .tick(tick), .sat_flag(sat_flag),
      .ilim_flag(ilim_flag), .goal(goal), .ref_q(ref_code)
   );

   assign gain_reg = (mode_q == MODE_REGULATE);

   assert_indep_reg_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && int'(src_sel) > N_RAILS) |=> gain_reg);

   assert_top_max_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !gain_reg && target == {REF_W{1'b1}} && int'(src_sel) <= N_RAILS) |=> !gain_reg);
endmodule

// File: tb/rail_track_ref_tb.sv
module rail_track_ref_tb;
   localparam int NR = 4;
   localparam int RW = 12;
   localparam int MAXC = 4095;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          tick = 1'b0;
   logic [2:0]    src_sel = '0;
   logic [NR*RW-1:0] rails_ref = '0;
   logic [RW-1:0] ext_track = '0;
   logic [7:0]    ratio = 8'd128;
   logic [RW-1:0] target = '0;
   logic          sat_flag = 1'b0;
   logic          ilim_flag = 1'b0;
   logic [RW-1:0] ref_code;
   logic          gain_reg;

   int n_chk = 0;
   int n_bad = 0;
   int m_ref = 0;
   int m_reg = 0;

   always #4 clk = ~clk;

   rail_track_ref u_dut (
      .clk(clk), .rst_n(rst_n), .tick(tick), .src_sel(src_sel),
      .rails_ref(rails_ref), .ext_track(ext_track), .ratio(ratio),
      .target(target), .sat_flag(sat_flag), .ilim_flag(ilim_flag),
      .ref_code(ref_code), .gain_reg(gain_reg)
   );

   function automatic int scale_of(int m, int r);
      int v;
      v = (m * r) >>> 7;
      return (v > MAXC) ? MAXC : v;
   endfunction

   task automatic chk(string tag, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic model_tick();
      int s, m, indep, nreg, goal, d;
      indep = 0;
      if (src_sel < NR) m = int'(rails_ref[src_sel*RW +: RW]);
      else if (src_sel == NR) m = int'(ext_track);
      else begin m = 0; indep = 1; end
      s = scale_of(m, int'(ratio));
      nreg = m_reg;
      if (indep) nreg = 1;
      else if (m_reg == 0 && s > int'(target)) nreg = 1;
      else if (m_reg == 1 && s + 20 < int'(target)) nreg = 0;
      goal = nreg ? int'(target) : s;
      if (ilim_flag) m_ref = (m_ref > 32) ? m_ref - 32 : 0;
      else if (!sat_flag) begin
         d = goal - m_ref;
         if (d > 16) d = 16;
         if (d < -16) d = -16;
         m_ref = m_ref + d;
      end
      m_reg = nreg;
   endtask

   task automatic do_tick(string tag);
      tick = 1'b1;
      @(posedge clk);
      model_tick();
      @(negedge clk);
      tick = 1'b0;
      chk({tag, " ref"}, int'(ref_code), m_ref);
      chk({tag, " gain"}, int'(gain_reg), m_reg);
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) begin
         @(posedge clk);
         @(negedge clk);
         chk("R7 ref quiet", int'(ref_code), m_ref);
         chk("R7 gain quiet", int'(gain_reg), m_reg);
      end
   endtask

   initial begin
      #(8 * 200000);
      n_bad++;
      n_chk++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      int prev;
      void'($urandom(32'd4242));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 reset ref", int'(ref_code), 0);
      chk("R1 reset gain", int'(gain_reg), 0);

      // R7: inputs move, no tick
      src_sel = 3'd4; ext_track = 12'd900; target = 12'd100; sat_flag = 1'b0;
      idle(4);

      // R3 + R6 + R10: rail 0 at half ratio, target at top code
      src_sel = 3'd0; rails_ref[0 +: RW] = 12'd1000; ratio = 8'd64; target = 12'hFFF;
      do_tick("R6 first step");
      chk("R6 first step value", int'(ref_code), 16);
      for (int i = 0; i < 40; i++) do_tick("R3 R10 converge");
      chk("R3 half ratio", int'(ref_code), 500);
      chk("R10 stays follow", int'(gain_reg), 0);
      rails_ref[0 +: RW] = 12'd4095; ratio = 8'd255;
      for (int i = 0; i < 10; i++) do_tick("R10 clamp");
      chk("R10 top target follow", int'(gain_reg), 0);
      chk("R3 clamp ramp", int'(ref_code), 660);

      // R2 external source at unit ratio
      src_sel = 3'd4; ext_track = 12'd800; ratio = 8'd128; target = 12'd2000;
      for (int i = 0; i < 20; i++) do_tick("R2 ext");
      chk("R2 ext value", int'(ref_code), 800);
      chk("R2 ext follow", int'(gain_reg), 0);

      // R4 enter regulation
      target = 12'd600;
      do_tick("R4 enter");
      chk("R4 gain set", int'(gain_reg), 1);
      for (int i = 0; i < 20; i++) do_tick("R4 settle");
      chk("R4 holds target", int'(ref_code), 600);

      // R5 band edges
      ext_track = 12'd580;
      do_tick("R5 band edge");
      chk("R5 in band stays reg", int'(gain_reg), 1);
      ext_track = 12'd579;
      do_tick("R5 below band");
      chk("R5 back to follow", int'(gain_reg), 0);
      chk("R5 ref follows", int'(ref_code), 584);

      // R8 saturation freeze, R9 foldback
      ext_track = 12'd1500; target = 12'd3000;
      do_tick("R6 ramp");
      prev = int'(ref_code);
      sat_flag = 1'b1;
      do_tick("R8 sat");
      chk("R8 frozen", int'(ref_code), prev);
      ilim_flag = 1'b1;
      do_tick("R9 fold");
      chk("R9 fold with sat", int'(ref_code), prev - 32);
      sat_flag = 1'b0;
      for (int i = 0; i < 25; i++) do_tick("R9 fold floor");
      chk("R9 floor zero", int'(ref_code), 0);
      ilim_flag = 1'b0;

      // R2 independent
      src_sel = 3'd6; target = 12'd40;
      do_tick("R2 indep");
      chk("R2 indep gain", int'(gain_reg), 1);
      do_tick("R2 indep");
      chk("R2 indep target", int'(ref_code), 32);

      // R6 source change without step
      src_sel = 3'd2; rails_ref[2*RW +: RW] = 12'd3000; target = 12'hFFF;
      prev = int'(ref_code);
      do_tick("R6 switch");
      chk("R6 switch step", int'(ref_code), prev + 16);

      // random phase checked by model
      for (int i = 0; i < 3000; i++) begin
         if ($urandom % 16 == 0) src_sel = 3'($urandom % 8);
         if ($urandom % 8 == 0) ext_track = 12'($urandom);
         if ($urandom % 8 == 0) rails_ref = 48'({$urandom, $urandom});
         if ($urandom % 32 == 0) ratio = 8'($urandom);
         if ($urandom % 16 == 0) target = 12'($urandom);
         sat_flag  = ($urandom % 8 == 0);
         ilim_flag = ($urandom % 16 == 0);
         if ($urandom % 2 == 0) do_tick("R4 R5 R6 R8 R9 random");
         else idle(1);
      end

      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule